// File: doc/BRIEF.md
# Carry-Chain ALU with Tracked Add/Subtract Mode

This block is the arithmetic unit of a small accumulator machine whose instruction word holds a 4-bit operation field. It offers plain addition, plain subtraction and one chained operation, "continue with carry". The chained operation adds with carry or subtracts with borrow. Which one it does is set by a stored mode bit. ADD clears that bit and SUB sets it, so a multi-byte sum or difference is written as one ADD or SUB followed by any number of continue steps.

The mode bit lives in the flags register beside the carry and zero flags. All three flags are visible on output ports so that an interrupt handler can save them. A synchronous restore port writes them back on return, so a chain that is cut between two steps resumes in the same direction. Results are registered and appear one cycle after the operation is accepted.

Top module: `chain_alu`

## Requirements
- R1: `op_sel` codes are 0 pass A, 1 ADD, 2 SUB, 3 continue-with-carry (RWC), 4 AND, 5 OR, 6 XOR, 7 pass B, and 8 to 15 pass A. An operation is accepted when `op_valid` is high and `restore_en` is low. Its result is on `result` with `res_valid` high in the next cycle. `result` holds its value in cycles that follow no accepted operation.
- R2: ADD gives A+B modulo 2^W, sets carry to the unsigned carry-out and sets the mode to add (`flag_sub_mode`=0).
- R3: SUB gives A-B modulo 2^W, sets carry to the borrow (A<B) and sets the mode to subtract (`flag_sub_mode`=1).
- R4: RWC in add mode gives A+B+C and sets carry to the carry-out.
- R5: RWC in subtract mode gives A-B-C and sets carry when A < B+C. RWC never changes the mode bit.
- R6: After every accepted operation, the zero flag is set exactly when the W-bit result is zero.
- R7: Non-arithmetic operations (codes 0 and 4 to 15) leave carry and mode unchanged.
- R8: `restore_en` loads carry from bit 0, zero from bit 1 and mode from bit 2 of `restore_flags` on the next edge. It has priority over an operation in the same cycle, which is then dropped and gives no `res_valid`.
- R9: Reset clears carry, zero, mode (add), `result` and `res_valid`. An RWC before any ADD or SUB therefore acts as A+B.
- R10: RWC with equal operands in subtract mode gives all ones when carry was set and zero when it was clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| restore_en | input | 1 | Load flags from `restore_flags` |
| restore_flags | input | 3 | Saved flags {mode, zero, carry} |
| result | output | W | Registered result |
| res_valid | output | 1 | Result of an accepted operation is on `result` |
| flag_carry | output | 1 | Carry (add) or borrow (subtract) |
| flag_zero | output | 1 | Last result was zero |
| flag_sub_mode | output | 1 | 1 when the last ADD/SUB was a subtraction |

## Verification
Four-byte additions and subtractions are run as chains and compared with a 32-bit reference. Operands are chosen so that carries and borrows cross every byte boundary, and others so that they do not, which shows whether the carry is fed forward in the right direction. One chain is cut by an unrelated subtraction and then a flags restore. Its correct 32-bit result can only come back if the mode bit and carry were saved and restored together. Further cases cover RWC straight after reset, logic operations placed between a carry-setting ADD and an RWC, a restore together with an operation in the same cycle, and the -1/0 carry-materialisation pair.

// File: rtl/chain_alu_pkg.sv
// Package chain_alu_pkg
// Shared operation codes and the flags record for the chained-carry ALU.
// Assumes a 4-bit operation field; codes 8..15 decode as pass-A.
package chain_alu_pkg;

    localparam int OPW = 4;

    localparam logic [OPW-1:0] OPC_PASS_A = 4'd0;
    localparam logic [OPW-1:0] OPC_ADD    = 4'd1;
    localparam logic [OPW-1:0] OPC_SUB    = 4'd2;
    localparam logic [OPW-1:0] OPC_RWC    = 4'd3;
    localparam logic [OPW-1:0] OPC_AND    = 4'd4;
    localparam logic [OPW-1:0] OPC_OR     = 4'd5;
    localparam logic [OPW-1:0] OPC_XOR    = 4'd6;
    localparam logic [OPW-1:0] OPC_PASS_B = 4'd7;

    // Flags layout: bit2 mode (1 = subtract), bit1 zero, bit0 carry.
    typedef struct packed {
        logic sub_mode;
        logic zero;
        logic carry;
    } alu_flags_t;

endpackage

// File: rtl/chain_addsub.sv
// Module chain_addsub
// Combinational W-bit adder/subtractor with carry or borrow in and out.
// Subtraction is A + ~B + ~borrow_in; the carry-out is inverted to form
// the borrow, so cy_out is always "carry" when adding and "borrow" when
// subtracting. Assumes W >= 1.
module chain_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    input  logic         cy_in,
    output logic [W-1:0] sum,
    output logic         cy_out
);

    localparam int EW = W + 1;

    logic [W-1:0]  b_eff;
    logic          ci_eff;
    logic [EW-1:0] ext;

    // Form the operand and carry-in for the shared adder.
    always_comb begin
        b_eff  = do_sub ? ~b : b;
        ci_eff = do_sub ? ~cy_in : cy_in;
        ext    = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci_eff};
    end

    // Split the extended sum into result and carry/borrow.
    always_comb begin
        sum    = ext[W-1:0];
        cy_out = do_sub ? ~ext[W] : ext[W];
    end

endmodule

// File: rtl/chain_logic.sv
// Module chain_logic
// Combinational non-arithmetic unit: pass-through and bitwise operations.
// Arithmetic codes are don't-care here (the top selects the adder);
// unlisted codes return operand A.
module chain_logic
    import chain_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);

    // Select the bitwise or pass-through result for the current code.
    always_comb begin
        case (op)
            OPC_AND:    y = a & b;
            OPC_OR:     y = a | b;
            OPC_XOR:    y = a ^ b;
            OPC_PASS_B: y = b;
            default:    y = a;
        endcase
    end

endmodule

// File: rtl/chain_flags.sv
// Module chain_flags
// Flags register holding carry, zero and the add/subtract mode bit.
// Restore has priority over an accepted operation. Zero follows every
// accepted operation, carry only arithmetic ones, mode only ADD and SUB.
// Assumes set_add and set_sub are never high together.
module chain_flags
    import chain_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restore_en,
    input  alu_flags_t restore_val,
    input  logic       accept,
    input  logic       is_arith,
    input  logic       set_add,
    input  logic       set_sub,
    input  logic       carry_new,
    input  logic       zero_new,
    output alu_flags_t flags_q
);

    // Update the flags from reset, restore or the accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (restore_en) begin
            flags_q <= restore_val;
        end else if (accept) begin
            flags_q.zero <= zero_new;
            if (is_arith) flags_q.carry <= carry_new;
            if (set_add) flags_q.sub_mode <= 1'b0;
            else if (set_sub) flags_q.sub_mode <= 1'b1;
        end
    end

    AST_RESTORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        restore_en |=> flags_q == $past(restore_val)); // R8

    AST_ADD_CLEARS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !restore_en && set_add) |=> !flags_q.sub_mode); // R2

    AST_SUB_SETS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !restore_en && set_sub) |=> flags_q.sub_mode); // R3

    AST_RWC_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !restore_en && is_arith && !set_add && !set_sub)
        |=> flags_q.sub_mode == $past(flags_q.sub_mode)); // R5

    AST_LOGIC_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !restore_en && !is_arith)
        |=> (flags_q.carry == $past(flags_q.carry))
            && (flags_q.sub_mode == $past(flags_q.sub_mode))); // R7

endmodule

// File: rtl/chain_alu.sv
// Module chain_alu (top)
// ALU with ADD, SUB and a continue-with-carry operation whose direction
// is taken from the stored mode bit. The result is registered one cycle
// after acceptance. Flags are exposed for saving and may be reloaded
// through the restore port, which wins over a simultaneous operation.
module chain_alu
    import chain_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_sel,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic           restore_en,
    input  logic [2:0]     restore_flags,
    output logic [W-1:0]   result,
    output logic           res_valid,
    output logic           flag_carry,
    output logic           flag_zero,
    output logic           flag_sub_mode
);

    alu_flags_t  flags_q;
    alu_flags_t  rest_val;
    logic        accept;
    logic        is_add, is_sub, is_rwc, is_arith;
    logic        use_sub, cy_feed;
    logic [W-1:0] as_sum, lg_y, y_next;
    logic        as_cy;

    // Decode the operation and pick the adder direction and carry feed.
    always_comb begin
        accept   = op_valid && !restore_en;
        is_add   = (op_sel == OPC_ADD);
        is_sub   = (op_sel == OPC_SUB);
        is_rwc   = (op_sel == OPC_RWC);
        is_arith = is_add || is_sub || is_rwc;
        use_sub  = is_sub || (is_rwc && flags_q.sub_mode);
        cy_feed  = is_rwc && flags_q.carry;
        rest_val = alu_flags_t'(restore_flags);
    end

    chain_addsub #(.W(W)) u_addsub (
        .a      (opnd_a),
        .b      (opnd_b),
        .do_sub (use_sub),
        .cy_in  (cy_feed),
        .sum    (as_sum),
        .cy_out (as_cy)
    );

    chain_logic #(.W(W)) u_logic (
        .op (op_sel),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (lg_y)
    );

    // Choose between the arithmetic and logic results.
    always_comb begin
        y_next = is_arith ? as_sum : lg_y;
    end

    chain_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .restore_en  (restore_en),
        .restore_val (rest_val),
        .accept      (accept),
        .is_arith    (is_arith),
        .set_add     (is_add),
        .set_sub     (is_sub),
        .carry_new   (as_cy),
        .zero_new    (y_next == '0),
        .flags_q     (flags_q)
    );

    // Register the result and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= accept;
            if (accept) result <= y_next;
        end
    end

    // Drive the flag outputs.
    always_comb begin
        flag_carry    = flags_q.carry;
        flag_zero     = flags_q.zero;
        flag_sub_mode = flags_q.sub_mode;
    end

    AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> res_valid); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> (!res_valid && $stable(result))); // R1

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flag_zero == (result == '0))); // R6

endmodule

// File: tb/tb_chain_alu.sv
`timescale 1ns/1ps
module tb_chain_alu;
    import chain_alu_pkg::*;

    localparam int W = 8;

    typedef struct {
        logic [W-1:0] res;
        logic c, z, m;
        logic chain;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [3:0] op_sel = '0;
    logic [W-1:0] opnd_a = '0, opnd_b = '0;
    logic restore_en = 1'b0;
    logic [2:0] restore_flags = '0;
    logic [W-1:0] result;
    logic res_valid, flag_carry, flag_zero, flag_sub_mode;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];
    logic [W-1:0] obs[$];
    logic m_c = 0, m_z = 0, m_m = 0;

    always #2.5 clk = ~clk;

    chain_alu #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .restore_en(restore_en),
        .restore_flags(restore_flags), .result(result), .res_valid(res_valid),
        .flag_carry(flag_carry), .flag_zero(flag_zero), .flag_sub_mode(flag_sub_mode)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare each produced result with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (sb.size() == 0) begin
                check(0, "R8", "unexpected res_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result == e.res, e.tag, "result", result, e.res);
                check({flag_sub_mode, flag_zero, flag_carry} == {e.m, e.z, e.c},
                      e.tag, "flags{m,z,c}", {flag_sub_mode, flag_zero, flag_carry},
                      {e.m, e.z, e.c});
                if (e.chain) obs.push_back(result);
            end
        end
    end

    // Driver: present one operation and push its expected outcome.
    task automatic do_op(input logic [3:0] op, input logic [W-1:0] a, b,
                         input string tag, input logic chain = 0);
        exp_t e;
        logic [W-1:0] y;
        logic sub, ci;
        int t;
        @(negedge clk);
        op_valid = 1; op_sel = op; opnd_a = a; opnd_b = b;
        if (op == OPC_ADD || op == OPC_SUB || op == OPC_RWC) begin
            sub = (op == OPC_SUB) || (op == OPC_RWC && m_m);
            ci  = (op == OPC_RWC) ? m_c : 1'b0;
            if (sub) begin
                t = int'(a) - int'(b) - int'(ci);
                m_c = (int'(a) < int'(b) + int'(ci));
            end else begin
                t = int'(a) + int'(b) + int'(ci);
                m_c = (t > 255);
            end
            y = t[W-1:0];
            if (op == OPC_ADD) m_m = 0;
            if (op == OPC_SUB) m_m = 1;
        end else begin
            case (op)
                OPC_AND: y = a & b;
                OPC_OR: y = a | b;
                OPC_XOR: y = a ^ b;
                OPC_PASS_B: y = b;
                default: y = a;
            endcase
        end
        m_z = (y == 0);
        e.res = y; e.c = m_c; e.z = m_z; e.m = m_m; e.chain = chain; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            op_valid = 0; restore_en = 0;
        end
    endtask

    // Restore flags, optionally with a colliding operation that must be dropped.
    task automatic restore(input logic [2:0] v, input logic with_op);
        @(negedge clk);
        restore_en = 1; restore_flags = v;
        op_valid = with_op; op_sel = OPC_ADD; opnd_a = 8'h01; opnd_b = 8'h01;
        {m_m, m_z, m_c} = v;
        @(negedge clk);
        restore_en = 0; op_valid = 0;
        check({flag_sub_mode, flag_zero, flag_carry} == v, "R8", "restored flags",
              {flag_sub_mode, flag_zero, flag_carry}, v);
    endtask

    // 32-bit add or subtract chain, optionally cut by a save/restore.
    task automatic chain32(input logic [31:0] a, b, input logic sub, input logic cut,
                           input string tag);
        logic [32:0] ref33;
        logic [31:0] got;
        logic [2:0] saved;
        obs.delete();
        do_op(sub ? OPC_SUB : OPC_ADD, a[7:0], b[7:0], tag, 1);
        do_op(OPC_RWC, a[15:8], b[15:8], tag, 1);
        if (cut) begin
            idle(1);
            saved = {flag_sub_mode, flag_zero, flag_carry};
            do_op(sub ? OPC_ADD : OPC_SUB, 8'h00, 8'h01, "R3");
            idle(1);
            restore(saved, 0);
        end
        do_op(OPC_RWC, a[23:16], b[23:16], tag, 1);
        do_op(OPC_RWC, a[31:24], b[31:24], tag, 1);
        idle(2);
        ref33 = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
        got = {obs[3], obs[2], obs[1], obs[0]};
        check(obs.size() == 4, tag, "chain length", obs.size(), 4);
        check(got == ref33[31:0], tag, "32-bit value", got, ref33[31:0]);
        check(flag_carry == ref33[32], tag, "32-bit carry/borrow", flag_carry, ref33[32]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WDOG", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state
        check({result, res_valid} == 0, "R9", "result/valid after reset", {result, res_valid}, 0);
        check({flag_sub_mode, flag_zero, flag_carry} == 0, "R9", "flags after reset",
              {flag_sub_mode, flag_zero, flag_carry}, 0);
        // R9/R4: RWC before any ADD/SUB acts as plain add
        do_op(OPC_RWC, 8'h10, 8'h20, "R9");
        idle(2);
        // R2, R6: ADD with carry-out and zero result
        do_op(OPC_ADD, 8'hFF, 8'h01, "R2");
        // R7: logic op keeps carry and mode
        do_op(OPC_AND, 8'hF0, 8'h0F, "R7");
        do_op(OPC_XOR, 8'hA5, 8'h0F, "R7");
        do_op(OPC_OR, 8'h00, 8'h00, "R6");
        do_op(OPC_PASS_B, 8'h11, 8'h22, "R1");
        do_op(4'd9, 8'h33, 8'h44, "R1");
        // R4: RWC consumes carry kept through logic ops
        do_op(OPC_RWC, 8'h01, 8'h01, "R4");
        idle(3);
        check(result == 8'h03, "R1", "result held while idle", result, 8'h03);
        // R3, R5: subtract chain step
        do_op(OPC_SUB, 8'h00, 8'h01, "R3");
        do_op(OPC_RWC, 8'h05, 8'h02, "R5");
        idle(2);
        // R10: carry materialisation
        do_op(OPC_SUB, 8'h10, 8'h20, "R10");
        do_op(OPC_RWC, 8'h55, 8'h55, "R10");
        do_op(OPC_SUB, 8'h20, 8'h10, "R10");
        do_op(OPC_RWC, 8'h55, 8'h55, "R10");
        idle(2);
        // Multi-byte chains (R4, R5)
        chain32(32'h89AB_CDEF, 32'h7654_3211, 0, 0, "R4");
        chain32(32'h0102_0304, 32'h1020_3040, 0, 0, "R4");
        chain32(32'h1000_0000, 32'h0000_0001, 1, 0, "R5");
        chain32(32'h0000_0005, 32'h0000_0009, 1, 0, "R5");
        // Interrupted chains (R8)
        chain32(32'h00FF_FFFF, 32'h0000_0001, 0, 1, "R8");
        chain32(32'h0100_0000, 32'h0000_0001, 1, 1, "R8");
        // R8: restore wins over a same-cycle operation
        restore(3'b101, 1);
        idle(2);
        check(res_valid == 0, "R8", "dropped op res_valid", res_valid, 0);
        do_op(OPC_RWC, 8'h09, 8'h03, "R8");
        idle(2);
        check(sb.size() == 0, "R1", "scoreboard drained", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule